// File: doc/BRIEF.md
# Packed Lane Adder with Selectable Saturation

This block adds or subtracts two 64-bit operands split into independent packed lanes. Software or a datapath controller picks the lane width for each operation: eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or a single 64-bit lane. No carry or borrow crosses a lane boundary, so one operation produces every lane result at once. A typical use is processing eight grey-level pixels per cycle.

Each operation runs in one of two modes. In wraparound mode a lane keeps only the low bits of its true result. In saturating mode a lane that leaves its representable range is held at the nearest limit. The limits are unsigned or two's-complement, chosen by a separate input. Saturation applies only to 8-bit and 16-bit lanes. Wider lanes always wrap.

The unit produces no status flags. It registers each result one clock after an input strobe and raises a valid strobe on that same cycle.

Top module: `psat_add_unit`

## Requirements
- R1: `lane_size` selects the lane width: 0 gives 8-bit lanes, 1 gives 16-bit, 2 gives 32-bit and 3 gives one 64-bit lane. Lane k occupies bits [k*W+W-1 : k*W]. A carry or borrow out of one lane never changes another lane.
- R2: With `sat_mode`=0 and `op_sub`=0, each lane equals (A + B) mod 2^W.
- R3: With `op_sub`=1, each lane is computed as A minus B. In wraparound mode the result is (A - B) mod 2^W.
- R4: With `sat_mode`=1, `signed_sat`=0 and an 8-bit or 16-bit lane width, an unsigned sum above the maximum becomes all ones (0xFF for bytes, 0xFFFF for words).
- R5: With `sat_mode`=1, `signed_sat`=0 and an 8-bit or 16-bit lane width, an unsigned difference below zero becomes 0.
- R6: With `sat_mode`=1, `signed_sat`=1 and an 8-bit or 16-bit lane width, a result is clamped to the two's-complement range: 0x7F/0x80 for bytes, 0x7FFF/0x8000 for words.
- R7: With 32-bit or 64-bit lanes, `sat_mode` and `signed_sat` have no effect, and the result wraps.
- R8: `result` and `out_valid` update on the clock edge that samples `in_valid`=1. In a cycle after `in_valid`=0, `out_valid` is 0 and `result` keeps its value.
- R9: While `rst_n` is low, `out_valid` and `result` are 0.
- R10: With `sat_mode`=0, `signed_sat` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 64 | Packed operand A |
| op_b | input | 64 | Packed operand B |
| op_sub | input | 1 | 0 = add, 1 = subtract (A - B) |
| lane_size | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit lanes |
| sat_mode | input | 1 | 0 = wraparound, 1 = saturating (8/16-bit lanes only) |
| signed_sat | input | 1 | 0 = unsigned limits, 1 = two's-complement limits |
| out_valid | output | 1 | Result valid strobe |
| result | output | 64 | Packed result |

## Verification
The embedded properties check several things on every cycle:
- the one-cycle valid timing, and that `result` holds when no strobe arrives;
- wrapped byte sums in the two lowest lanes, which shows that the carry stops at the byte boundary;
- the direction of unsigned byte saturation: a saturating sum never drops below A, and a saturating difference never rises above A;
- that a signed 16-bit sum of two non-negative operands never turns negative.

Only the bench scenarios can show the following:
- the exact clamp values at every lane width;
- that 32-bit and 64-bit lanes ignore the saturation controls;
- that the signedness input is inert in wraparound mode;
- that every lane matches an independent model over boundary and random operands.

// File: rtl/psat_pkg.sv
package psat_pkg;

   // True when segment g is the lowest segment of its lane for the size code ls.
   function automatic logic is_lane_base(input int g, input logic [1:0] ls);
      int unsigned m;
      m = (32'd1 << ls) - 32'd1;
      return (unsigned'(g) & m) == 32'd0;
   endfunction

   // Index of the most significant segment of the lane holding segment g.
   function automatic int lane_top(input int g, input logic [1:0] ls, input int nseg);
      int unsigned m;
      int          t;
      m = (32'd1 << ls) - 32'd1;
      t = int'(unsigned'(g) | m);
      if (t > nseg - 1) t = nseg - 1;
      return t;
   endfunction

endpackage

// File: rtl/psat_seg_add.sv
module psat_seg_add #(
   parameter int SEG_W   = 8,
   parameter int NUM_SEG = 8,
   localparam int DW     = SEG_W * NUM_SEG
) (
   input  logic [DW-1:0]      a,
   input  logic [DW-1:0]      b,
   input  logic               sub,
   input  logic [1:0]         ls,
   output logic [DW-1:0]      sum,
   output logic [NUM_SEG-1:0] cout,
   output logic [NUM_SEG-1:0] ovf
);

   logic [DW-1:0] bx;

   assign bx = sub ? ~b : b;

   for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
      localparam int LO = g * SEG_W;
      localparam int HI = LO + SEG_W - 1;
      logic         cin;
      logic [SEG_W:0] s;

      if (g == 0) begin : g_first
         assign cin = sub;
      end else begin : g_rest
         logic lane_start;
         assign lane_start = psat_pkg::is_lane_base(g, ls);
         assign cin = lane_start ? sub : g_seg[g-1].s[SEG_W];
      end

      assign s = {1'b0, a[HI:LO]} + {1'b0, bx[HI:LO]} + {{SEG_W{1'b0}}, cin};
      assign sum[HI:LO] = s[SEG_W-1:0];
      assign cout[g]    = s[SEG_W];
      assign ovf[g]     = (a[HI] == bx[HI]) && (s[SEG_W-1] != a[HI]);
   end

endmodule

// File: rtl/psat_clamp.sv
module psat_clamp #(
   parameter int SEG_W    = 8,
   parameter int NUM_SEG  = 8,
   parameter int SAT_LVLS = 2,
   localparam int DW      = SEG_W * NUM_SEG
) (
   input  logic [DW-1:0]      a,
   input  logic [DW-1:0]      sum,
   input  logic [NUM_SEG-1:0] cout,
   input  logic [NUM_SEG-1:0] ovf,
   input  logic               sub,
   input  logic [1:0]         ls,
   input  logic               sat_en,
   input  logic               sgn,
   output logic [DW-1:0]      res
);

   logic sat_ok;

   assign sat_ok = sat_en && (int'(ls) < SAT_LVLS);

   for (genvar g = 0; g < NUM_SEG; g++) begin : g_lane
      localparam int LO = g * SEG_W;
      localparam int HI = LO + SEG_W - 1;
      int               t;
      logic             go_hi;
      logic             go_lo;
      logic [SEG_W-1:0] hi_v;
      logic [SEG_W-1:0] lo_v;
      logic [SEG_W-1:0] seg_res;

      always_comb begin
         t = psat_pkg::lane_top(g, ls, NUM_SEG);
         if (sgn) begin
            go_hi = ovf[t] && !a[t*SEG_W + SEG_W - 1];
            go_lo = ovf[t] &&  a[t*SEG_W + SEG_W - 1];
         end else begin
            go_hi = !sub &&  cout[t];
            go_lo =  sub && !cout[t];
         end
         hi_v = '1;
         lo_v = '0;
         if (sgn && (g == t)) begin
            hi_v[SEG_W-1] = 1'b0;
            lo_v[SEG_W-1] = 1'b1;
         end
         if (!sat_ok)    seg_res = sum[HI:LO];
         else if (go_hi) seg_res = hi_v;
         else if (go_lo) seg_res = lo_v;
         else            seg_res = sum[HI:LO];
      end

      assign res[HI:LO] = seg_res;
   end

endmodule

// File: rtl/psat_add_unit.sv
module psat_add_unit #(
   parameter int SEG_W    = 8,
   parameter int NUM_SEG  = 8,
   parameter int SAT_LVLS = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [SEG_W*NUM_SEG-1:0] op_a,
   input  logic [SEG_W*NUM_SEG-1:0] op_b,
   input  logic                     op_sub,
   input  logic [1:0]               lane_size,
   input  logic                     sat_mode,
   input  logic                     signed_sat,
   output logic                     out_valid,
   output logic [SEG_W*NUM_SEG-1:0] result
);

   localparam int DW     = SEG_W * NUM_SEG;
   localparam int NSIZES = $clog2(NUM_SEG) + 1;

   if (NUM_SEG < 1 || NUM_SEG > 8 || (NUM_SEG & (NUM_SEG - 1)) != 0) begin : g_bad_nseg
      $error("NUM_SEG must be a power of two no larger than 8");
   end
   if (SEG_W < 2) begin : g_bad_segw
      $error("SEG_W must be at least 2");
   end
   if (SAT_LVLS < 0 || SAT_LVLS > NSIZES) begin : g_bad_sat
      $error("SAT_LVLS exceeds the number of lane sizes");
   end

   logic [DW-1:0]      sum;
   logic [DW-1:0]      clamped;
   logic [NUM_SEG-1:0] cout;
   logic [NUM_SEG-1:0] ovf;

   psat_seg_add #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_add (
      .a    (op_a),
      .b    (op_b),
      .sub  (op_sub),
      .ls   (lane_size),
      .sum  (sum),
      .cout (cout),
      .ovf  (ovf)
   );

   psat_clamp #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG), .SAT_LVLS(SAT_LVLS)) u_clamp (
      .a      (op_a),
      .sum    (sum),
      .cout   (cout),
      .ovf    (ovf),
      .sub    (op_sub),
      .ls     (lane_size),
      .sat_en (sat_mode),
      .sgn    (signed_sat),
      .res    (clamped)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= clamped;
      end
   end

   // R8: valid timing and result hold
   a_r8_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(result)));

   // R2: wrapped byte sum in lane 0
   a_r2_byte_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !op_sub && !sat_mode && lane_size == 2'd0)
      |=> result[SEG_W-1:0] == $past(SEG_W'(op_a[SEG_W-1:0] + op_b[SEG_W-1:0])));

   // R1: lane 1 unaffected by lane 0 carry in byte mode
   a_r1_lane_isolate: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !op_sub && !sat_mode && lane_size == 2'd0)
      |=> result[2*SEG_W-1:SEG_W] == $past(SEG_W'(op_a[2*SEG_W-1:SEG_W] + op_b[2*SEG_W-1:SEG_W])));

   // R4: unsigned saturating byte sum never below A
   a_r4_usat_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sat_mode && !signed_sat && !op_sub && lane_size == 2'd0)
      |=> result[SEG_W-1:0] >= $past(op_a[SEG_W-1:0]));

   // R5: unsigned saturating byte difference never above A
   a_r5_usub_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sat_mode && !signed_sat && op_sub && lane_size == 2'd0)
      |=> result[SEG_W-1:0] <= $past(op_a[SEG_W-1:0]));

   // R6: signed saturating 16-bit sum of non-negatives stays non-negative
   a_r6_ssat_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sat_mode && signed_sat && !op_sub && lane_size == 2'd1
       && !op_a[2*SEG_W-1] && !op_b[2*SEG_W-1])
      |=> !result[2*SEG_W-1]);

endmodule

// File: tb/psat_add_unit_tb.sv
module psat_add_unit_tb_top;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] op_a = '0;
   logic [63:0] op_b = '0;
   logic        op_sub = 1'b0;
   logic [1:0]  lane_size = 2'd0;
   logic        sat_mode = 1'b0;
   logic        signed_sat = 1'b0;
   logic        out_valid;
   logic [63:0] result;

   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_P/2) clk = ~clk;

   psat_add_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .op_a(op_a), .op_b(op_b), .op_sub(op_sub), .lane_size(lane_size),
      .sat_mode(sat_mode), .signed_sat(signed_sat),
      .out_valid(out_valid), .result(result)
   );

   function automatic logic [63:0] ref_model(input logic [63:0] a, input logic [63:0] b,
                                             input logic sub, input logic [1:0] ls,
                                             input logic sat, input logic sgn);
      int w;
      int n;
      logic [63:0] mask;
      logic [63:0] r;
      w = 8 << ls;
      n = 64 / w;
      mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
      r = '0;
      for (int l = 0; l < n; l++) begin
         logic [63:0]        ea, eb;
         logic signed [66:0] x, y, t, mx, mn;
         ea = (a >> (l*w)) & mask;
         eb = (b >> (l*w)) & mask;
         x = {3'b000, ea};
         y = {3'b000, eb};
         if (sgn && ea[w-1]) x = x - (67'sd1 <<< w);
         if (sgn && eb[w-1]) y = y - (67'sd1 <<< w);
         t = sub ? (x - y) : (x + y);
         if (sat && w <= 16) begin
            if (sgn) begin
               mx = (67'sd1 <<< (w-1)) - 67'sd1;
               mn = -(67'sd1 <<< (w-1));
            end else begin
               mx = (67'sd1 <<< w) - 67'sd1;
               mn = 67'sd0;
            end
            if (t > mx) t = mx;
            if (t < mn) t = mn;
         end
         r = r | ((t[63:0] & mask) << (l*w));
      end
      return r;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_vec(input string req, input logic [63:0] a, input logic [63:0] b,
                          input logic sub, input logic [1:0] ls, input logic sat,
                          input logic sgn, output logic [63:0] got);
      @(negedge clk);
      op_a = a; op_b = b; op_sub = sub; lane_size = ls;
      sat_mode = sat; signed_sat = sgn; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      got = result;
      check({req, " valid"}, {63'd0, out_valid}, 64'd1);
   endtask

   task automatic run_ref(input string req, input logic [63:0] a, input logic [63:0] b,
                          input logic sub, input logic [1:0] ls, input logic sat,
                          input logic sgn);
      logic [63:0] got;
      run_vec(req, a, b, sub, ls, sat, sgn, got);
      check(req, got, ref_model(a, b, sub, ls, sat, sgn));
   endtask

   function automatic logic [63:0] bval(input int i);
      case (i)
         0: return 64'h0000_0000_0000_0000;
         1: return 64'hFFFF_FFFF_FFFF_FFFF;
         2: return 64'h7F7F_7F7F_7F7F_7F7F;
         3: return 64'h8080_8080_8080_8080;
         4: return 64'h0101_0101_0101_0101;
         5: return 64'h7FFF_7FFF_8000_8000;
         6: return 64'h7FFF_FFFF_8000_0000;
         default: return 64'h00FF_7F80_0180_FF01;
      endcase
   endfunction

   task automatic t_reset;
      check("R9 reset valid", {63'd0, out_valid}, 64'd0);
      check("R9 reset result", result, 64'd0);
   endtask

   task automatic t_wrap;
      logic [63:0] got;
      run_vec("R1 byte carry isolation", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101,
              1'b0, 2'd0, 1'b0, 1'b0, got);
      check("R1 byte carry isolation", got, 64'h0);
      run_vec("R1 word carry isolation", 64'h0000_FFFF_0000_FFFF, 64'h0001_0001_0001_0001,
              1'b0, 2'd1, 1'b0, 1'b0, got);
      check("R1 word carry isolation", got, 64'h0001_0000_0001_0000);
      run_vec("R2 qword wrap", 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 1'b0, 2'd3, 1'b0, 1'b0, got);
      check("R2 qword wrap", got, 64'h1);
      run_ref("R2 mixed bytes", 64'hFF_FF_80_7F_01_00_F0_10, 64'h01_02_80_01_FF_00_20_F0,
              1'b0, 2'd0, 1'b0, 1'b0);
   endtask

   task automatic t_sub;
      logic [63:0] got;
      run_vec("R3 byte borrow wrap", 64'h0010_0010_0010_0010, 64'h0020_0020_0020_0020,
              1'b1, 2'd0, 1'b0, 1'b0, got);
      check("R3 byte borrow wrap", got, 64'h00F0_00F0_00F0_00F0);
      run_vec("R3 dword sub", 64'h0000_0000_0000_0005, 64'h0000_0001_0000_0007,
              1'b1, 2'd2, 1'b0, 1'b0, got);
      check("R3 dword sub", got, 64'hFFFF_FFFF_FFFF_FFFE);
   endtask

   task automatic t_usat;
      logic [63:0] got;
      run_vec("R4 unsigned byte clamp", 64'hF0F0_F0F0_F0F0_F0F0, 64'h2020_2020_2020_2020,
              1'b0, 2'd0, 1'b1, 1'b0, got);
      check("R4 unsigned byte clamp", got, 64'hFFFF_FFFF_FFFF_FFFF);
      run_vec("R4 unsigned word clamp", 64'hFFF0_0001_8000_0000, 64'h0020_0001_8000_0000,
              1'b0, 2'd1, 1'b1, 1'b0, got);
      check("R4 unsigned word clamp", got, 64'hFFFF_0002_FFFF_0000);
      run_vec("R5 unsigned byte floor", 64'h1010_1010_1010_1050, 64'h2020_2020_2020_2020,
              1'b1, 2'd0, 1'b1, 1'b0, got);
      check("R5 unsigned byte floor", got, 64'h0000_0000_0000_0030);
      run_vec("R5 unsigned word floor", 64'h0001_0005_0000_0000, 64'h0002_0003_0000_0000,
              1'b1, 2'd1, 1'b1, 1'b0, got);
      check("R5 unsigned word floor", got, 64'h0000_0002_0000_0000);
   endtask

   task automatic t_ssat;
      logic [63:0] got;
      run_vec("R6 signed byte clamp", 64'h7F80_7F80_7F80_7F80, 64'h01FF_01FF_01FF_01FF,
              1'b0, 2'd0, 1'b1, 1'b1, got);
      check("R6 signed byte clamp", got, 64'h7F80_7F80_7F80_7F80);
      run_vec("R6 signed word sub clamp", 64'h8000_7FFF_0000_0005, 64'h0001_FFFF_0000_0003,
              1'b1, 2'd1, 1'b1, 1'b1, got);
      check("R6 signed word sub clamp", got, 64'h8000_7FFF_0000_0002);
   endtask

   task automatic t_wide;
      logic [63:0] got;
      run_vec("R7 dword ignores saturation", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001,
              1'b0, 2'd2, 1'b1, 1'b0, got);
      check("R7 dword ignores saturation", got, 64'h0);
      run_vec("R7 qword ignores signed saturation", 64'h7FFF_FFFF_FFFF_FFFF, 64'h1,
              1'b0, 2'd3, 1'b1, 1'b1, got);
      check("R7 qword ignores signed saturation", got, 64'h8000_0000_0000_0000);
   endtask

   task automatic t_sign_inert;
      logic [63:0] g0, g1;
      run_vec("R10 wrap unsigned", 64'h7F80_7FFF_8000_FF01, 64'h0180_0001_FFFF_01FF,
              1'b0, 2'd0, 1'b0, 1'b0, g0);
      run_vec("R10 wrap signed", 64'h7F80_7FFF_8000_FF01, 64'h0180_0001_FFFF_01FF,
              1'b0, 2'd0, 1'b0, 1'b1, g1);
      check("R10 signedness inert in wrap", g1, g0);
   endtask

   task automatic t_timing;
      logic [63:0] got;
      run_vec("R8 strobe", 64'h1234, 64'h1111, 1'b0, 2'd1, 1'b0, 1'b0, got);
      @(negedge clk);
      op_a = 64'hDEAD_BEEF; op_b = 64'h5555; in_valid = 1'b0;
      @(negedge clk);
      check("R8 idle valid low", {63'd0, out_valid}, 64'd0);
      check("R8 idle result held", result, 64'h2345);
   endtask

   task automatic t_sweep;
      for (int ia = 0; ia < 8; ia++)
         for (int ib = 0; ib < 8; ib++)
            for (int cfg = 0; cfg < 32; cfg++)
               run_ref("R1 R4 R5 R6 R7 boundary sweep", bval(ia), bval(ib), cfg[0],
                       cfg[2:1], cfg[3], cfg[4]);
   endtask

   task automatic t_random;
      for (int i = 0; i < 400; i++) begin
         logic [63:0] a, b;
         logic [4:0]  cfg;
         a = {$urandom, $urandom};
         b = {$urandom, $urandom};
         cfg = 5'($urandom);
         run_ref("R2 R3 R6 random", a, b, cfg[0], cfg[2:1], cfg[3], cfg[4]);
      end
   endtask

   initial begin
      #(CLK_P * 200000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_wrap();
      t_sub();
      t_usat();
      t_ssat();
      t_wide();
      t_sign_inert();
      t_timing();
      t_sweep();
      t_random();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule